// File: doc/BRIEF.md
# USB Device Interrupt Status Router

This block keeps the device-level interrupt status word of a USB device controller. Single-cycle event pulses from the rest of the controller (bus reset, suspend change, connect change, command register empty, command data full, receive and transmit end of packet, endpoint realized, error) are caught in sticky status bits. An internal frame timer sets the frame bit once per frame period, which is 1 ms at the default clock count.

Per-endpoint interrupt lines are routed into one of two status bits. Each endpoint has a priority bit in a mask: an endpoint with priority 1 sets the fast bit and an endpoint with priority 0 sets the slow bit.

A small register port reads the status word, clears status bits by writing ones to a clear address, and reads and writes the contribution mask, the endpoint priority mask and the global enable. The interrupt line to the system interrupt controller is high when the global enable is set and at least one status bit is both set and selected by the contribution mask.

Top module: `usbd_irq_status`

## Requirements
- R1: After reset the status word reads 0x0000_0010 (only the command-empty bit, bit 4, is set). The contribution mask and the priority mask read 0, the global enable reads 1, and irq_out is 0.
- R2: The frame bit (bit 0) is set once every FRAME_CYCLES clock cycles. The first time is FRAME_CYCLES cycles after the internal reset is released.
- R3: During a cycle with an endpoint line high, the fast bit (bit 1) is set if that endpoint's priority bit is 1 and the slow bit (bit 2) is set if it is 0. Both bits can be set in the same cycle.
- R4: The device-status bit (bit 3) is set by a bus-reset pulse, a suspend-change pulse or a connect-change pulse.
- R5: The remaining events set their own bits: command empty bit 4, command data full bit 5, receive end of packet bit 6, transmit end of packet bit 7, endpoint realized bit 8, error bit 9. Bits 31:10 of the status word always read 0.
- R6: Status bits are sticky. Writing to the clear address (1) clears each bit whose written bit is 1. Written 0 bits leave the status unchanged.
- R7: If a set event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: Writes to the status address (0) do not change the status word.
- R9: irq_out is 1 exactly when the global enable (address 4, bit 0) is 1 and the status word ANDed with the contribution mask (address 2, bits 9:0) is nonzero.
- R10: The contribution mask (address 2), the priority mask (address 3, NUM_EP bits) and the global enable (address 4) read back what was written, limited to their widths. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_bus_reset | input | 1 | Bus reset event pulse |
| ev_suspend_chg | input | 1 | Suspend state change pulse |
| ev_connect_chg | input | 1 | Connect state change pulse |
| ev_cmd_empty | input | 1 | Command register empty pulse |
| ev_cmd_full | input | 1 | Command data full pulse |
| ev_rx_end | input | 1 | Receive end of packet pulse |
| ev_tx_end | input | 1 | Transmit end of packet pulse |
| ev_ep_realized | input | 1 | Endpoint realized pulse |
| ev_error | input | 1 | Error pulse |
| ep_irq | input | NUM_EP | Per-endpoint interrupt lines |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_out | output | 1 | Gated interrupt to the system interrupt controller |

## Verification
An event or an endpoint line that is high at a clock edge shows up in the status word right after that edge. A register write takes effect at the edge where reg_wr is sampled. reg_rdata and irq_out are combinational from the registers, so both follow in the same cycle as the register update. The bench drives pulses and writes on the falling edge and samples one falling edge later, which is the first point at which the registered result can be seen. For the frame period it counts falling edges between two frame-bit settings, and it masks the frame bit out of every other status comparison.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;
  localparam int unsigned STAT_W   = 10;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 3;

  localparam int unsigned B_FRAME  = 0;
  localparam int unsigned B_FAST   = 1;
  localparam int unsigned B_SLOW   = 2;
  localparam int unsigned B_DEV    = 3;
  localparam int unsigned B_CEMPTY = 4;
  localparam int unsigned B_CFULL  = 5;
  localparam int unsigned B_RXEND  = 6;
  localparam int unsigned B_TXEND  = 7;
  localparam int unsigned B_REAL   = 8;
  localparam int unsigned B_ERR    = 9;

  localparam logic [STAT_W-1:0] STAT_RST = 10'h010;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_CLEAR  = 3'd1,
    A_MASK   = 3'd2,
    A_PRIO   = 3'd3,
    A_GLOBAL = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/usbd_irq_frame_timer.sv
module usbd_irq_frame_timer #(
  parameter int unsigned FRAME_CYCLES = 48000
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

  generate
    if (FRAME_CYCLES > 1) begin : g_chk
      // R2
      frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/usbd_irq_ep_router.sv
module usbd_irq_ep_router #(
  parameter int unsigned NUM_EP = 32
) (
  input  logic [NUM_EP-1:0] ep_irq_i,
  input  logic [NUM_EP-1:0] prio_i,
  output logic              fast_o,
  output logic              slow_o
);
  logic [NUM_EP-1:0] fast_v, slow_v;

  genvar e;
  generate
    for (e = 0; e < NUM_EP; e++) begin : g_ep
      assign fast_v[e] = ep_irq_i[e] &  prio_i[e];
      assign slow_v[e] = ep_irq_i[e] & ~prio_i[e];
    end
  endgenerate

  assign fast_o = |fast_v;
  assign slow_o = |slow_v;
endmodule

// File: rtl/usbd_irq_sticky.sv
module usbd_irq_sticky #(
  parameter int unsigned WIDTH = 10,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q, q_d;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      always_comb begin
        if (set_i[b])      q_d[b] = 1'b1;
        else if (clr_i[b]) q_d[b] = 1'b0;
        else               q_d[b] = q_q[b];
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) q_q[b] <= RST_VAL[b];
        else         q_q[b] <= q_d[b];
      end

      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        set_i[b] |=> q_o[b]);
      // R6
      clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (!set_i[b] && clr_i[b]) |=> !q_o[b]);
      // R6
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (!set_i[b] && !clr_i[b]) |=> $stable(q_o[b]));
    end
  endgenerate

  assign q_o = q_q;
endmodule

// File: rtl/usbd_irq_cfg.sv
module usbd_irq_cfg
  import usbd_irq_pkg::*;
#(
  parameter int unsigned NUM_EP = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [STAT_W-1:0] mask_o,
  output logic [NUM_EP-1:0] prio_o,
  output logic              glb_o
);
  logic [STAT_W-1:0] mask_q, mask_d;
  logic [NUM_EP-1:0] prio_q, prio_d;
  logic              glb_q,  glb_d;
  logic              mask_en, prio_en, glb_en;

  always_comb begin
    mask_en = wr_i && (addr_i == A_MASK);
    prio_en = wr_i && (addr_i == A_PRIO);
    glb_en  = wr_i && (addr_i == A_GLOBAL);
    mask_d  = mask_en ? wdata_i[STAT_W-1:0] : mask_q;
    prio_d  = prio_en ? wdata_i[NUM_EP-1:0] : prio_q;
    glb_d   = glb_en  ? wdata_i[0]          : glb_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      prio_q <= '0;
      glb_q  <= 1'b1;
    end else begin
      mask_q <= mask_d;
      prio_q <= prio_d;
      glb_q  <= glb_d;
    end
  end

  assign mask_o = mask_q;
  assign prio_o = prio_q;
  assign glb_o  = glb_q;

  // R10
  glb_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    glb_en |=> (glb_o == $past(wdata_i[0])));
endmodule

// File: rtl/usbd_irq_status.sv
module usbd_irq_status
  import usbd_irq_pkg::*;
#(
  parameter int unsigned NUM_EP       = 32,
  parameter int unsigned FRAME_CYCLES = 48000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_bus_reset,
  input  logic              ev_suspend_chg,
  input  logic              ev_connect_chg,
  input  logic              ev_cmd_empty,
  input  logic              ev_cmd_full,
  input  logic              ev_rx_end,
  input  logic              ev_tx_end,
  input  logic              ev_ep_realized,
  input  logic              ev_error,
  input  logic [NUM_EP-1:0] ep_irq,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              frame_tick, ep_fast, ep_slow;
  logic [STAT_W-1:0] set_v, clr_v, stat, mask;
  logic [NUM_EP-1:0] prio;
  logic              glb;

  initial begin
    if (NUM_EP < 1 || NUM_EP > DATA_W) $error("NUM_EP out of range");
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  usbd_irq_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
    .clk(clk), .rst_ni(rst_ni), .tick_o(frame_tick));

  usbd_irq_ep_router #(.NUM_EP(NUM_EP)) u_router (
    .ep_irq_i(ep_irq), .prio_i(prio), .fast_o(ep_fast), .slow_o(ep_slow));

  usbd_irq_cfg #(.NUM_EP(NUM_EP)) u_cfg (
    .clk(clk), .rst_ni(rst_ni), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .mask_o(mask), .prio_o(prio), .glb_o(glb));

  always_comb begin
    set_v           = '0;
    set_v[B_FRAME]  = frame_tick;
    set_v[B_FAST]   = ep_fast;
    set_v[B_SLOW]   = ep_slow;
    set_v[B_DEV]    = ev_bus_reset | ev_suspend_chg | ev_connect_chg;
    set_v[B_CEMPTY] = ev_cmd_empty;
    set_v[B_CFULL]  = ev_cmd_full;
    set_v[B_RXEND]  = ev_rx_end;
    set_v[B_TXEND]  = ev_tx_end;
    set_v[B_REAL]   = ev_ep_realized;
    set_v[B_ERR]    = ev_error;
    clr_v = (reg_wr && reg_addr == A_CLEAR) ? reg_wdata[STAT_W-1:0] : '0;
  end

  usbd_irq_sticky #(.WIDTH(STAT_W), .RST_VAL(STAT_RST)) u_stat (
    .clk(clk), .rst_ni(rst_ni), .set_i(set_v), .clr_i(clr_v), .q_o(stat));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS: reg_rdata[STAT_W-1:0] = stat;
      A_MASK:   reg_rdata[STAT_W-1:0] = mask;
      A_PRIO:   reg_rdata[NUM_EP-1:0] = prio;
      A_GLOBAL: reg_rdata[0]          = glb;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_out = glb & (|(stat & mask));

  // R3
  ep_fast_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (|(ep_irq & prio)) |=> reg_rdata[B_FAST] || reg_addr != A_STATUS);
  // R3
  ep_slow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (|(ep_irq & ~prio)) |=> stat[B_SLOW]);
  // R4
  dev_stat_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ev_bus_reset || ev_suspend_chg || ev_connect_chg) |=> stat[B_DEV]);
  // R8
  status_ro_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && reg_addr == A_STATUS && !frame_tick && !ep_fast && !ep_slow
     && !set_v[B_DEV] && set_v[STAT_W-1:B_CEMPTY] == '0) |=> $stable(stat));
endmodule

// File: tb/usbd_irq_status_bench.sv
`timescale 1ns/1ps
module usbd_irq_status_bench;
  localparam int NEP = 32;
  localparam int FC  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_bus_reset = 0, ev_suspend_chg = 0, ev_connect_chg = 0;
  logic ev_cmd_empty = 0, ev_cmd_full = 0, ev_rx_end = 0, ev_tx_end = 0;
  logic ev_ep_realized = 0, ev_error = 0;
  logic [NEP-1:0] ep_irq = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  usbd_irq_status #(.NUM_EP(NEP), .FRAME_CYCLES(FC)) u_usbd_irq_status (
    .clk(clk), .rst_n(rst_n),
    .ev_bus_reset(ev_bus_reset), .ev_suspend_chg(ev_suspend_chg),
    .ev_connect_chg(ev_connect_chg), .ev_cmd_empty(ev_cmd_empty),
    .ev_cmd_full(ev_cmd_full), .ev_rx_end(ev_rx_end), .ev_tx_end(ev_tx_end),
    .ev_ep_realized(ev_ep_realized), .ev_error(ev_error), .ep_irq(ep_irq),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // status with the free-running frame bit masked away
  task automatic rd_stat(output logic [31:0] d);
    rd(3'd0, d);
    d[0] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_stat(d);    chk("R1 status", d, 32'h10);
    rd(3'd2, d);   chk("R1 mask", d, 0);
    rd(3'd3, d);   chk("R1 prio", d, 0);
    rd(3'd4, d);   chk("R1 global", d, 1);
    chk("R1 irq", {31'd0, irq_out}, 0);
    rd(3'd6, d);   chk("R10 unused addr", d, 0);
  endtask

  task automatic t_status_ro;
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF);
    rd_stat(d); chk("R8 status write ignored", d, 32'h10);
    wr(3'd1, 32'h0000_0000);
    rd_stat(d); chk("R6 zero clear no effect", d, 32'h10);
    wr(3'd1, 32'h0000_03FF);
    rd_stat(d); chk("R6 clear cmd empty", d, 0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    for (int k = 0; k < 9; k++) begin
      logic [31:0] exp;
      @(negedge clk);
      case (k)
        0: ev_bus_reset = 1;   1: ev_suspend_chg = 1; 2: ev_connect_chg = 1;
        3: ev_cmd_empty = 1;   4: ev_cmd_full = 1;    5: ev_rx_end = 1;
        6: ev_tx_end = 1;      7: ev_ep_realized = 1; default: ev_error = 1;
      endcase
      @(negedge clk);
      {ev_bus_reset, ev_suspend_chg, ev_connect_chg, ev_cmd_empty, ev_cmd_full,
       ev_rx_end, ev_tx_end, ev_ep_realized, ev_error} = '0;
      exp = (k < 3) ? 32'h8 : (32'h10 << (k - 3));
      rd_stat(d);
      chk(k < 3 ? "R4 device status" : "R5 event bit", d, exp);
      wr(3'd1, 32'h3FF);
    end
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R5 upper bits zero", d & 32'hFFFF_FC00, 0);
  endtask

  task automatic t_sticky_clear;
    logic [31:0] d;
    @(negedge clk); ev_rx_end = 1; ev_error = 1; ev_cmd_full = 1;
    @(negedge clk); ev_rx_end = 0; ev_error = 0; ev_cmd_full = 0;
    repeat (3) @(negedge clk);
    rd_stat(d); chk("R6 sticky", d, 32'h260);
    wr(3'd1, 32'h0000_0040);
    rd_stat(d); chk("R6 partial clear", d, 32'h220);
    // set and clear of bit 9 in the same cycle
    @(negedge clk);
    ev_error = 1; reg_addr = 3'd1; reg_wdata = 32'h3FE; reg_wr = 1;
    @(negedge clk);
    ev_error = 0; reg_wr = 0;
    rd_stat(d); chk("R7 set wins", d, 32'h200);
    wr(3'd1, 32'h3FF);
  endtask

  task automatic t_router;
    logic [31:0] d;
    wr(3'd3, 32'h0000_00F0);
    rd(3'd3, d); chk("R10 prio readback", d, 32'hF0);
    @(negedge clk); ep_irq = 32'h0000_0020;
    @(negedge clk); ep_irq = '0;
    rd_stat(d); chk("R3 fast", d, 32'h2);
    wr(3'd1, 32'h3FF);
    @(negedge clk); ep_irq = 32'h8000_0001;
    @(negedge clk); ep_irq = '0;
    rd_stat(d); chk("R3 slow", d, 32'h4);
    wr(3'd1, 32'h3FF);
    @(negedge clk); ep_irq = 32'h0000_0081;
    @(negedge clk); ep_irq = '0;
    rd_stat(d); chk("R3 fast and slow", d, 32'h6);
    wr(3'd1, 32'h3FF);
    wr(3'd3, 32'hFFFF_FFFF);
    @(negedge clk); ep_irq = 32'h8000_0000;
    @(negedge clk); ep_irq = '0;
    rd_stat(d); chk("R3 top endpoint fast", d, 32'h2);
    wr(3'd1, 32'h3FF);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(3'd2, 32'hFFFF_F080);
    rd(3'd2, d); chk("R10 mask width", d, 32'h80);
    #1 chk("R9 idle low", {31'd0, irq_out}, 0);
    @(negedge clk); ev_rx_end = 1;
    @(negedge clk); ev_rx_end = 0;
    #1 chk("R9 unmasked bit no irq", {31'd0, irq_out}, 0);
    @(negedge clk); ev_tx_end = 1;
    @(negedge clk); ev_tx_end = 0;
    #1 chk("R9 irq high", {31'd0, irq_out}, 1);
    wr(3'd4, 32'hFFFF_FFFE);
    rd(3'd4, d); chk("R10 global readback", d, 0);
    chk("R9 global gate", {31'd0, irq_out}, 0);
    wr(3'd4, 32'h1);
    #1 chk("R9 global on", {31'd0, irq_out}, 1);
    wr(3'd1, 32'h080);
    #1 chk("R9 cleared", {31'd0, irq_out}, 0);
    wr(3'd1, 32'h3FF);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_frame;
    logic [31:0] d;
    int n;
    n = 0;
    do begin @(negedge clk); rd(3'd0, d); n++; end while (!d[0] && n < 4*FC);
    chk("R2 frame seen", {31'd0, d[0]}, 1);
    reg_addr = 3'd1; reg_wdata = 32'h1; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    rd(3'd0, d); chk("R2 frame cleared", {31'd0, d[0]}, 0);
    n = 1;
    do begin @(negedge clk); rd(3'd0, d); n++; end while (!d[0] && n < 4*FC);
    chk("R2 frame period", n, FC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_status_ro();
    t_events();
    t_sticky_clear();
    t_router();
    t_irq();
    t_frame();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule